// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers up to 29 level-sensitive interrupt sources into one request line. Each source owns one bit of a 32-bit cause word, at positions 1 through 29. While a source input is high, its cause bit is set, and the bit stays set until software clears it. A 32-bit mask word chooses which pending causes may raise the request. The three remaining cause positions (0, 30 and 31) hold no source. They read back as summary ORs over fixed groups of source bits, so a handler can decide with one read which group to scan.

Software uses a small register port with a write strobe, a read strobe and a byte offset. To acknowledge a source, software writes back the cause word it last read with the serviced bit set to zero. A cause bit can only be cleared by a write; writing 1 never sets it. Alongside the request line, the block outputs the number of the lowest pending enabled source and a flag that is high when nothing is pending. A dispatcher can take the next source from these outputs without scanning the word itself.

Top module: `irq_cause_ctrl`

## Requirements
- R1: While source input `src_i[k]` is high at a rising clock edge, cause bit k+1 is set after that edge. The bit stays set after the input falls.
- R2: A cause write never sets a bit: writing 1 to any cause position leaves a clear bit clear. When a source is high in the same cycle as a write that clears its bit, the bit ends up set.
- R3: A cause write at offset 0 clears every source bit written as 0. Every pending bit written as 1 stays set.
- R4: Cause read bit 0 is the OR of cause bits 29..1.
- R5: Cause read bit 30 is the OR of cause bits 29..26 and 20..1.
- R6: Cause read bit 31 is the OR of cause bits 25..1.
- R7: A write at offset 4 loads the mask. Bits 29..1 are stored and read back as written. Mask bits 0, 30 and 31 always read 0. Summary bits ignore the mask, and writes to positions 0, 30 and 31 have no effect on them.
- R8: `irq_o` is high exactly when (cause AND mask) is nonzero in bits 29..1. It follows a register change in the cycle after the clock edge that makes the change.
- R9: `irq_idx_o` gives the lowest bit number (1..29) that is both pending and enabled. When no such bit exists, `irq_idx_o` is 0 and `none_o` is 1.
- R10: After reset, the cause and mask words are both zero, `irq_o` is 0 and `none_o` is 1.
- R11: When `rd_en_i` is high at a clock edge, `rdata_o` holds the addressed word after that edge. Offset 0 returns cause, offset 4 returns mask, and any other offset returns 0.
- R12: Writing 0 to both registers leaves no source pending or enabled. `irq_o` is then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 29 | Level source inputs; src_i[k] drives cause bit k+1 |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Byte offset: 0 for cause, 4 for mask |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request |
| irq_idx_o | output | 5 | Lowest pending enabled source number |
| none_o | output | 1 | High when no enabled source is pending |

## Verification
Source events and register writes take effect at the clock edge where they are sampled. The request line, index and no-pending flag are combinational from the two registers, so they are valid at the next falling edge. Read data is registered, so it is valid at the falling edge that follows the read strobe's rising edge. The bench drives every stimulus on a falling edge, holds it for exactly one rising edge, and samples the outputs at the following falling edge, where each result is due.

// File: rtl/irq_cc_pkg.sv
// Package: shared widths, register offsets and summary group masks for
// the interrupt cause/mask controller. Assumes a 32-bit register word.
package irq_cc_pkg;
    localparam int REG_W   = 32;
    localparam int SRC_LO  = 1;
    localparam int SRC_HI  = 29;
    localparam int NUM_SRC = SRC_HI - SRC_LO + 1;
    localparam int IDX_W   = $clog2(REG_W);
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] OFS_CAUSE = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 3'd4;

    // Summary bit positions inside the cause read word
    localparam int SUM_ALL_POS = 0;
    localparam int SUM_A_POS   = 30;
    localparam int SUM_B_POS   = 31;

    // Build a mask with ones from bit lo up to bit hi
    function automatic logic [REG_W-1:0] span(input int hi, input int lo);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < REG_W; i++)
            if (i >= lo && i <= hi) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] SRC_BITS = span(SRC_HI, SRC_LO);
    localparam logic [REG_W-1:0] GRP_A    = span(29, 26) | span(20, 1);
    localparam logic [REG_W-1:0] GRP_B    = span(25, 1);
endpackage

// File: rtl/irq_cause_bank.sv
// Cause storage: latches level source events and clears bits that a
// write supplies as zero. Assumes set_i carries only source positions.
module irq_cause_bank
    import irq_cc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] cause_o
);
    logic [REG_W-1:0] cause_q;
    logic [REG_W-1:0] kept;

    // Bits that survive this cycle: a write may only clear
    always_comb begin
        kept = wr_i ? (cause_q & wdata_i) : cause_q;
    end

    // Register update; a new event wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (kept | set_i) & SRC_BITS;
    end

    assign cause_o = cause_q;

    AST_NO_WRITE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(set_i)) == '0)); // R2
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & $past(set_i)) == $past(set_i))); // R1
    AST_ACK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> ((cause_q & $past(wdata_i & cause_q)) == $past(wdata_i & cause_q))); // R3
endmodule

// File: rtl/irq_mask_bank.sv
// Mask storage: holds the enable bits of the source positions only.
// Assumes the caller qualifies wr_i with the mask offset.
module irq_mask_bank
    import irq_cc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] mask_o
);
    logic [REG_W-1:0] mask_q;

    // Load source enable bits on write
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_q <= '0;
        else if (wr_i) mask_q <= wdata_i & SRC_BITS;
    end

    assign mask_o = mask_q;

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (mask_q == ($past(wdata_i) & SRC_BITS))); // R7
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_q)); // R7
endmodule

// File: rtl/irq_lowest_enc.sv
// Priority encoder: reports the lowest set bit of pend_i.
// Assumes pend_i bit 0 is never set, so index 0 means none.
module irq_lowest_enc
    import irq_cc_pkg::*;
(
    input  logic [REG_W-1:0] pend_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             none_o
);
    // Scan from the top down so the lowest set bit is taken last
    always_comb begin
        idx_o = '0;
        for (int i = REG_W - 1; i >= 0; i--)
            if (pend_i[i]) idx_o = IDX_W'(i);
        none_o = (pend_i == '0);
    end

    always_comb begin
        if (!none_o) begin
            AST_IDX_SET: assert (pend_i[idx_o]); // R9
            AST_IDX_LOWEST: assert ((pend_i & ((REG_W'(1) << idx_o) - REG_W'(1))) == '0); // R9
        end
    end
endmodule

// File: rtl/irq_cause_ctrl.sv
// Top: interrupt cause/mask controller with summary ORs, a request line,
// a lowest-source index and a registered read port. Assumes single-cycle
// write and read strobes and byte offsets 0 (cause) and 4 (mask).
module irq_cause_ctrl
    import irq_cc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic [REG_W-1:0]   rdata_o,
    output logic               irq_o,
    output logic [IDX_W-1:0]   irq_idx_o,
    output logic               none_o
);
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] cause;
    logic [REG_W-1:0] mask;
    logic [REG_W-1:0] pend;
    logic [REG_W-1:0] cause_rd;
    logic             wr_cause;
    logic             wr_mask;

    // Place each source input on its cause position
    always_comb begin
        set_vec = '0;
        for (int k = 0; k < NUM_SRC; k++)
            set_vec[k + SRC_LO] = src_i[k];
    end

    assign wr_cause = wr_en_i && (addr_i == OFS_CAUSE);
    assign wr_mask  = wr_en_i && (addr_i == OFS_MASK);

    irq_cause_bank u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .wr_i    (wr_cause),
        .wdata_i (wdata_i),
        .cause_o (cause)
    );

    irq_mask_bank u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_mask),
        .wdata_i (wdata_i),
        .mask_o  (mask)
    );

    // Enabled pending sources
    assign pend  = cause & mask & SRC_BITS;
    assign irq_o = |pend;

    irq_lowest_enc u_enc (
        .pend_i (pend),
        .idx_o  (irq_idx_o),
        .none_o (none_o)
    );

    // Cause read word with the three summary ORs merged in
    always_comb begin
        cause_rd = cause & SRC_BITS;
        cause_rd[SUM_ALL_POS] = |(cause & SRC_BITS);
        cause_rd[SUM_A_POS]   = |(cause & GRP_A);
        cause_rd[SUM_B_POS]   = |(cause & GRP_B);
    end

    // Registered read data mux
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_o <= '0;
        else if (rd_en_i) begin
            case (addr_i)
                OFS_CAUSE: rdata_o <= cause_rd;
                OFS_MASK:  rdata_o <= mask;
                default:   rdata_o <= '0;
            endcase
        end
    end

    AST_IRQ_VS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !none_o); // R8
    AST_RD_SUM_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == OFS_CAUSE) |=> (rdata_o[SUM_ALL_POS] == |$past(cause))); // R4
    AST_RD_SUM_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == OFS_CAUSE) |=> (rdata_o[SUM_B_POS] == |($past(cause) & GRP_B))); // R6
    AST_RD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == OFS_MASK) |=> (rdata_o == $past(mask))); // R11
endmodule

// File: tb/irq_cause_ctrl_tb_top.sv
// Directed bench for the cause/mask controller; one task per scenario.
module irq_cause_ctrl_tb_top;
    import irq_cc_pkg::*;

    localparam int CLK_P = 10;
    localparam logic [31:0] SRC_M = 32'h3FFF_FFFE;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] src_i = '0;
    logic               wr_en_i = 1'b0;
    logic               rd_en_i = 1'b0;
    logic [ADDR_W-1:0]  addr_i = '0;
    logic [REG_W-1:0]   wdata_i = '0;
    logic [REG_W-1:0]   rdata_o;
    logic               irq_o;
    logic [IDX_W-1:0]   irq_idx_o;
    logic               none_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [31:0] m_cause = '0;
    logic [31:0] m_mask = '0;

    always #(CLK_P/2) clk = ~clk;

    irq_cause_ctrl dut_i (.*);

    // Check helper: one FAIL line on mismatch
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected cause read word from the bench model
    function automatic logic [31:0] exp_cause();
        logic [31:0] w;
        w = m_cause & SRC_M;
        w[0]  = |(m_cause & SRC_M);
        w[30] = |(m_cause & 32'h3C1F_FFFE);
        w[31] = |(m_cause & 32'h03FF_FFFE);
        return w;
    endfunction

    // Expected lowest pending enabled source number
    function automatic logic [31:0] exp_idx();
        logic [31:0] p;
        p = m_cause & m_mask & SRC_M;
        for (int i = 1; i < 30; i++) if (p[i]) return i;
        return 0;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en_i = 1'b1; addr_i = a;
        @(negedge clk);
        rd_en_i = 1'b0;
        d = rdata_o;
    endtask

    task automatic pulse(input int b);
        @(negedge clk);
        src_i[b-1] = 1'b1;
        @(negedge clk);
        src_i[b-1] = 1'b0;
        m_cause[b] = 1'b1;
    endtask

    task automatic chk_outs(input string req);
        chk({req, " irq"}, 32'(irq_o), 32'(|(m_cause & m_mask & SRC_M)));
        chk({req, " idx"}, 32'(irq_idx_o), exp_idx());
        chk({req, " none"}, 32'(none_o), 32'(exp_idx() == 0));
    endtask

    task automatic clear_all();
        wr(OFS_MASK, '0); wr(OFS_CAUSE, '0);
        m_mask = '0; m_cause = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R10 irq", 32'(irq_o), 0);
        chk("R10 none", 32'(none_o), 1);
        rd(OFS_CAUSE, d); chk("R10 cause", d, 0);
        rd(OFS_MASK, d);  chk("R10 mask", d, 0);
    endtask

    task automatic t_latch();
        logic [31:0] d;
        pulse(5);
        rd(OFS_CAUSE, d); chk("R1 latch", d, 32'hC000_0021);
        chk_outs("R8 masked off");
    endtask

    task automatic t_summary();
        logic [31:0] d;
        clear_all();
        pulse(27);
        rd(OFS_CAUSE, d); chk("R5 group A only", d, 32'h4800_0001);
        clear_all();
        pulse(22);
        rd(OFS_CAUSE, d); chk("R6 group B only", d, 32'h8040_0001);
        pulse(29);
        rd(OFS_CAUSE, d); chk("R4 all", d, exp_cause());
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(OFS_MASK, 32'hFFFF_FFFF); m_mask = SRC_M;
        rd(OFS_MASK, d); chk("R7 mask readback", d, SRC_M);
        rd(OFS_CAUSE, d); chk("R7 summary ignores mask", d, exp_cause());
        chk_outs("R8 enabled");
    endtask

    task automatic t_prio();
        logic [31:0] d;
        clear_all();
        wr(OFS_MASK, SRC_M); m_mask = SRC_M;
        pulse(12); pulse(7); pulse(3);
        chk("R9 lowest", 32'(irq_idx_o), 3);
        rd(OFS_CAUSE, d);
        wr(OFS_CAUSE, d & ~32'h8); m_cause[3] = 1'b0;
        chk("R3 ack next", 32'(irq_idx_o), 7);
        rd(OFS_CAUSE, d); chk("R3 others kept", d, exp_cause());
        wr(OFS_MASK, SRC_M & ~32'h80); m_mask[7] = 1'b0;
        chk_outs("R9 masked skip");
        chk("R9 idx 12", 32'(irq_idx_o), 12);
    endtask

    task automatic t_write_one();
        logic [31:0] d;
        clear_all();
        wr(OFS_CAUSE, 32'hFFFF_FFFF);
        rd(OFS_CAUSE, d); chk("R2 write one no set", d, 0);
    endtask

    task automatic t_race();
        logic [31:0] d;
        pulse(9);
        @(negedge clk);
        src_i[8] = 1'b1; wr_en_i = 1'b1; addr_i = OFS_CAUSE; wdata_i = '0;
        @(negedge clk);
        src_i[8] = 1'b0; wr_en_i = 1'b0;
        m_cause = 32'h200;
        rd(OFS_CAUSE, d); chk("R2 event beats clear", d, exp_cause());
    endtask

    task automatic t_offsets();
        logic [31:0] d;
        rd(3'd2, d); chk("R11 unused offset", d, 0);
        rd(OFS_CAUSE, d); chk("R11 cause offset", d, exp_cause());
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(OFS_MASK, SRC_M); m_mask = SRC_M;
        clear_all();
        chk_outs("R12 cleared");
        rd(OFS_CAUSE, d); chk("R12 cause zero", d, 0);
        rd(OFS_MASK, d);  chk("R12 mask zero", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_summary();
        t_mask();
        t_prio();
        t_write_one();
        t_race();
        t_offsets();
        t_clear();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule